// File: doc/BRIEF.md
# Command-List Sequencer with Host Synchronization

This block is the control unit of a signal-processing coprocessor. It walks a list of 16-bit commands held in a local command RAM and hands each command to an execution unit. A host processor drives it through a small register window. Writing a start address into the pointer register launches the list. Reading the status register shows whether the list is still running. Writing the abort register stops it. A sticky interrupt-status flag, gated by a mask bit, drives an active-low interrupt pin whenever a list ends.

The sequencer ends on its own when it decodes a halt, a breakpoint or a reserved opcode. It also ends when the host touches anything other than the synchronization registers while a list is running. Such an access is refused and counts as a violation. Every other command is issued to the execution unit with a valid/done handshake, and the pointer then steps on by one. Host accesses to the command RAM and to the pointer are only honoured while the sequencer is idle.

Top module: `cmdlist_seq`

## Requirements
- R1: A command word carries its opcode in bits 15:11 and its argument in bits 10:0. Opcode 5'h1F is halt, 5'h1E is breakpoint, 5'h1C and 5'h1D are reserved, and every other opcode is a generic command.
- R2: A host write to the pointer register (index 0) while idle starts execution at the written value modulo the RAM depth, and the status register bit 0 (busy flag) reads 1.
- R3: A generic command is presented on exec_cmd with exec_valid high and is held stable until exec_done. After exec_done the pointer advances by one, wrapping from the last RAM word to word 0, and the next command is fetched.
- R4: Halt or breakpoint ends execution without issuing the command, and the pointer is left at that command's address.
- R5: A reserved opcode ends execution without issuing the command.
- R6: Any host write to the abort register (index 2), whatever its data, ends a running list at once and withdraws exec_valid. While idle it has no effect.
- R7: While busy, a host access to the pointer register, to the spare index 7 or to the command RAM ends execution. The access itself is dropped: a write is not performed and a read returns 0.
- R8: While busy, accesses to status (1), abort (2), external-disable (3), interrupt-status (4), mask (5) and NMI-status (6) do not disturb execution. Index 3 and index 6 read 0 and ignore writes.
- R9: Every termination sets interrupt-status bit 0. The bit stays set until the host writes it with data bit 0 equal to 1. Writing it with data bit 0 equal to 0 leaves it unchanged.
- R10: irq_n is low exactly when interrupt-status bit 0 and mask bit 0 are both 1.
- R11: After reset the sequencer is idle, interrupt-status and mask read 0, irq_n is 1 and exec_valid is 0.
- R12: A host address with its top bit set selects RAM word host_addr[ADDR_W-1:0]. With the top bit clear it selects register host_addr[2:0]; any nonzero middle bits select the spare. Read data appears on host_rdata in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W+1 | Host address: RAM word or register index |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, registered |
| exec_valid | output | 1 | A command is offered to the execution unit |
| exec_cmd | output | 16 | Command word offered |
| exec_done | input | 1 | Execution unit has finished the offered command |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with ADDR_W = 5, which gives a 32-word command RAM and a 6-bit host address. With so small a RAM, a start value of 16'hFFFF folds onto the last word, so the step from word 31 to word 0 is covered by a two-command list. Keeping RSVD_MASK at its default marks opcodes 5'h1C and 5'h1D as reserved. Every termination cause, along with the exempt and the refused host accesses, is then driven at a known cycle of the fetch, decode and issue loop.

// File: rtl/cmdseq_pkg.sv
// Package cmdseq_pkg
// Shared widths, opcode values, register indices and the sequencer state type
// for the command-list sequencer. Assumes a 16-bit command word.
package cmdseq_pkg;

    localparam int CMD_W = 16;
    localparam int OPC_W = 5;
    localparam int OPC_LSB = CMD_W - OPC_W;

    localparam logic [OPC_W-1:0] OPC_HALT  = 5'h1F;
    localparam logic [OPC_W-1:0] OPC_BRKPT = 5'h1E;

    localparam logic [2:0] RG_PTR    = 3'd0;
    localparam logic [2:0] RG_STAT   = 3'd1;
    localparam logic [2:0] RG_ABORT  = 3'd2;
    localparam logic [2:0] RG_EXTOFF = 3'd3;
    localparam logic [2:0] RG_ISTAT  = 3'd4;
    localparam logic [2:0] RG_MASK   = 3'd5;
    localparam logic [2:0] RG_NMI    = 3'd6;
    localparam logic [2:0] RG_SPARE  = 3'd7;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_FETCH  = 2'd1,
        SQ_DECODE = 2'd2,
        SQ_EXEC   = 2'd3
    } seq_state_t;

    // Registers that the host may touch while a list runs.
    function automatic logic reg_exempt(input logic [2:0] idx);
        return (idx != RG_PTR) && (idx != RG_SPARE);
    endfunction

endpackage

// File: rtl/cmd_ram.sv
// Module cmd_ram
// Command storage: one write port owned by the host and two asynchronous
// read ports, one for the host and one for the fetch stage. The contents are
// not reset; the host is assumed to load every word before executing it.
module cmd_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] host_q,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] fetch_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Host write into the word selected by the host address.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[host_addr] <= wr_data;
        end
    end

    // Combinational reads for both ports.
    always_comb begin
        host_q  = mem[host_addr];
        fetch_q = mem[fetch_addr];
    end

endmodule

// File: rtl/host_regs.sv
// Module host_regs
// Host-side decode: splits the address into RAM or register space, detects
// aborts and protected accesses made while busy, keeps the sticky halt flag
// and the mask, registers read data, and drives the active-low interrupt.
// Assumes one-cycle host strobes and a term pulse from the sequencer.
module host_regs
    import cmdseq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W:0]   addr,
    input  logic [CMD_W-1:0]  wdata,
    input  logic              run,
    input  logic [ADDR_W-1:0] ptr,
    input  logic              term,
    input  logic [CMD_W-1:0]  ram_q,
    output logic              start,
    output logic [ADDR_W-1:0] start_addr,
    output logic              stop,
    output logic              ram_we,
    output logic [CMD_W-1:0]  rdata,
    output logic              irq_n
);
    localparam int HA_W = ADDR_W + 1;

    logic       ram_sel;
    logic [2:0] reg_idx;
    logic       reg_acc;
    logic       exempt;
    logic       violation;
    logic       halt_flag;
    logic       mask_q;

    // Address split: the top bit picks RAM, nonzero middle bits fold to spare.
    always_comb begin
        ram_sel = addr[HA_W-1];
        reg_idx = (addr[HA_W-2:3] == '0) ? addr[2:0] : RG_SPARE;
        reg_acc = req && !ram_sel;
        exempt  = !ram_sel && reg_exempt(reg_idx);
    end

    // Start, stop and RAM write decisions.
    always_comb begin
        violation  = req && run && !exempt;
        stop       = violation || (reg_acc && we && reg_idx == RG_ABORT);
        start      = reg_acc && we && reg_idx == RG_PTR && !run;
        start_addr = wdata[ADDR_W-1:0];
        ram_we     = req && we && ram_sel && !run;
    end

    // Sticky halt flag: set on termination, cleared by writing a one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_flag <= 1'b0;
        end else if (term) begin
            halt_flag <= 1'b1;
        end else if (reg_acc && we && reg_idx == RG_ISTAT && wdata[0]) begin
            halt_flag <= 1'b0;
        end
    end

    // Interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else if (reg_acc && we && reg_idx == RG_MASK) begin
            mask_q <= wdata[0];
        end
    end

    // Registered read data; refused reads return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (req && !we) begin
            if (violation) begin
                rdata <= '0;
            end else if (ram_sel) begin
                rdata <= ram_q;
            end else begin
                case (reg_idx)
                    RG_PTR:   rdata <= CMD_W'(ptr);
                    RG_STAT:  rdata <= CMD_W'(run);
                    RG_ISTAT: rdata <= CMD_W'(halt_flag);
                    RG_MASK:  rdata <= CMD_W'(mask_q);
                    default:  rdata <= '0;
                endcase
            end
        end
    end

    // Interrupt output, active low.
    always_comb begin
        irq_n = !(halt_flag && mask_q);
    end

    assert_flag_on_term_R9: assert property (@(posedge clk) disable iff (!rst_n)
        term |=> halt_flag);

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> (halt_flag && mask_q));

endmodule

// File: rtl/seq_fsm.sv
// Module seq_fsm
// Fetch / decode / issue loop. It holds the command pointer and the current
// command word. It ends the list on halt, breakpoint or a reserved opcode, or
// when the host side raises stop. Assumes exec_done is only meaningful while
// exec_valid is high.
module seq_fsm
    import cmdseq_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [31:0] RSVD_MASK = 32'h3000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              stop,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              exec_done,
    output logic              run,
    output logic [ADDR_W-1:0] ptr,
    output logic              exec_valid,
    output logic [CMD_W-1:0]  exec_cmd,
    output logic              term
);
    seq_state_t        state;
    logic [CMD_W-1:0]  ir;
    logic [OPC_W-1:0]  opc;
    logic              is_end;

    // Decode of the ending command classes.
    always_comb begin
        opc    = ir[CMD_W-1:OPC_LSB];
        is_end = (opc == OPC_HALT) || (opc == OPC_BRKPT) || RSVD_MASK[opc];
        run    = (state != SQ_IDLE);
        term   = (run && stop) || (state == SQ_DECODE && is_end);
        exec_valid = (state == SQ_EXEC);
        exec_cmd   = ir;
    end

    // State, pointer and command register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            ptr   <= '0;
            ir    <= '0;
        end else if (run && stop) begin
            state <= SQ_IDLE;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        ptr   <= start_addr;
                        state <= SQ_FETCH;
                    end
                end
                SQ_FETCH: begin
                    ir    <= cmd_word;
                    state <= SQ_DECODE;
                end
                SQ_DECODE: begin
                    state <= is_end ? SQ_IDLE : SQ_EXEC;
                end
                SQ_EXEC: begin
                    if (exec_done) begin
                        ptr   <= ptr + 1'b1;
                        state <= SQ_FETCH;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (run && ptr == $past(start_addr)));

    assert_cmd_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && !exec_done && !stop) |=> (exec_valid && $stable(exec_cmd)));

    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_done && !stop) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    assert_stop_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && stop) |=> !run);

endmodule

// File: rtl/cmdlist_seq.sv
// Module cmdlist_seq
// Top level of the command-list sequencer: the command RAM, the host register
// decode and the fetch/issue state machine. The host address is one bit wider
// than the RAM address; its top bit selects the RAM.
module cmdlist_seq
    import cmdseq_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [31:0] RSVD_MASK = 32'h3000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W:0]   host_addr,
    input  logic [CMD_W-1:0]  host_wdata,
    output logic [CMD_W-1:0]  host_rdata,
    output logic              exec_valid,
    output logic [CMD_W-1:0]  exec_cmd,
    input  logic              exec_done,
    output logic              irq_n
);
    logic              run;
    logic [ADDR_W-1:0] ptr;
    logic              term;
    logic              start;
    logic [ADDR_W-1:0] start_addr;
    logic              stop;
    logic              ram_we;
    logic [CMD_W-1:0]  ram_host_q;
    logic [CMD_W-1:0]  ram_fetch_q;

    cmd_ram #(.ADDR_W(ADDR_W), .DATA_W(CMD_W)) u_ram (
        .clk        (clk),
        .wr_en      (ram_we),
        .host_addr  (host_addr[ADDR_W-1:0]),
        .wr_data    (host_wdata),
        .host_q     (ram_host_q),
        .fetch_addr (ptr),
        .fetch_q    (ram_fetch_q)
    );

    host_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (host_req),
        .we         (host_we),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .run        (run),
        .ptr        (ptr),
        .term       (term),
        .ram_q      (ram_host_q),
        .start      (start),
        .start_addr (start_addr),
        .stop       (stop),
        .ram_we     (ram_we),
        .rdata      (host_rdata),
        .irq_n      (irq_n)
    );

    seq_fsm #(.ADDR_W(ADDR_W), .RSVD_MASK(RSVD_MASK)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .stop       (stop),
        .cmd_word   (ram_fetch_q),
        .exec_done  (exec_done),
        .run        (run),
        .ptr        (ptr),
        .exec_valid (exec_valid),
        .exec_cmd   (exec_cmd),
        .term       (term)
    );

    assert_no_ram_write_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> !ram_we);

endmodule

// File: tb/cmdlist_seq_tb.sv
// Directed bench for cmdlist_seq, one task per scenario.
module cmdlist_seq_tb;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic [AW:0]   host_addr = '0;
    logic [15:0]   host_wdata = '0;
    logic [15:0]   host_rdata;
    logic          exec_valid;
    logic [15:0]   exec_cmd;
    logic          exec_done = 1'b0;
    logic          irq_n;

    int vecs = 0;
    int errs = 0;

    always #2.5 clk = ~clk;

    cmdlist_seq #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .exec_valid(exec_valid), .exec_cmd(exec_cmd), .exec_done(exec_done),
        .irq_n(irq_n)
    );

    function automatic logic [AW:0] ra(input int a);
        return {1'b1, 5'(a)};
    endfunction
    function automatic logic [AW:0] rg(input int i);
        return {3'b000, 3'(i)};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW:0] a, input logic [15:0] d);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic rd(input logic [AW:0] a, output logic [15:0] d);
        host_req = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_req = 1'b0;
        d = host_rdata;
    endtask

    // Acknowledge every offered command for a number of cycles.
    task automatic serve(input int cyc, output int n, output logic [15:0] c0, output logic [15:0] c1);
        n = 0; c0 = '0; c1 = '0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (exec_valid && !exec_done) begin
                if (n == 0) c0 = exec_cmd;
                if (n == 1) c1 = exec_cmd;
                n++;
                exec_done = 1'b1;
            end else begin
                exec_done = 1'b0;
            end
        end
        exec_done = 1'b0;
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 20 && !exec_valid; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R11 irq_n", 16'(irq_n), 16'h1);
        chk("R11 exec_valid", 16'(exec_valid), 16'h0);
        rd(rg(1), d); chk("R11 stat", d, 16'h0);
        rd(rg(4), d); chk("R11 istat", d, 16'h0);
        rd(rg(5), d); chk("R11 mask", d, 16'h0);
    endtask

    task automatic t_basic();
        logic [15:0] d, c0, c1; int n;
        wr(ra(2), 16'h0812);
        wr(ra(3), 16'h57FF);
        wr(ra(4), 16'hF800);
        rd(ra(3), d); chk("R12 ram readback", d, 16'h57FF);
        wr(rg(0), 16'h0002);
        serve(30, n, c0, c1);
        chk("R3 issued count", 16'(n), 16'd2);
        chk("R1 R3 first cmd", c0, 16'h0812);
        chk("R3 second cmd", c1, 16'h57FF);
        rd(rg(1), d); chk("R4 idle after halt", d, 16'h0);
        rd(rg(0), d); chk("R4 ptr at halt", d, 16'h4);
        rd(rg(4), d); chk("R9 flag set", d, 16'h1);
        chk("R10 masked irq", 16'(irq_n), 16'h1);
        wr(rg(4), 16'h0000); rd(rg(4), d); chk("R9 write0 keeps", d, 16'h1);
        wr(rg(4), 16'h0001); rd(rg(4), d); chk("R9 write1 clears", d, 16'h0);
    endtask

    task automatic t_brk_irq();
        logic [15:0] d, c0, c1; int n;
        wr(rg(5), 16'h0001);
        chk("R10 mask only", 16'(irq_n), 16'h1);
        wr(ra(10), 16'hF123);
        wr(rg(0), 16'd10);
        serve(20, n, c0, c1);
        chk("R4 brk not issued", 16'(n), 16'd0);
        rd(rg(0), d); chk("R4 ptr at brk", d, 16'd10);
        chk("R10 irq low", 16'(irq_n), 16'h0);
        wr(rg(4), 16'h0001);
        chk("R10 irq released", 16'(irq_n), 16'h1);
        wr(rg(5), 16'h0000);
    endtask

    task automatic t_reserved();
        logic [15:0] d, c0, c1; int n;
        wr(ra(12), 16'h0001);
        wr(ra(13), 16'hE000);
        wr(ra(14), 16'h0002);
        wr(rg(0), 16'd12);
        serve(30, n, c0, c1);
        chk("R5 only one issued", 16'(n), 16'd1);
        rd(rg(0), d); chk("R5 ptr at reserved", d, 16'd13);
        rd(rg(4), d); chk("R5 flag", d, 16'h1);
        wr(rg(4), 16'h0001);
    endtask

    task automatic t_wrap();
        logic [15:0] d, c0, c1; int n;
        wr(ra(31), 16'h1234);
        wr(ra(0), 16'hF800);
        wr(rg(0), 16'hFFFF);
        serve(30, n, c0, c1);
        chk("R2 start folded", c0, 16'h1234);
        chk("R3 wrap count", 16'(n), 16'd1);
        rd(rg(0), d); chk("R3 ptr wrapped", d, 16'd0);
        wr(rg(4), 16'h0001);
    endtask

    task automatic t_abort();
        logic [15:0] d;
        wr(ra(5), 16'h0A55);
        wr(ra(6), 16'hF800);
        wr(rg(0), 16'd5);
        wait_valid();
        chk("R2 running", 16'(exec_valid), 16'h1);
        wr(rg(2), 16'h0000);
        chk("R6 valid withdrawn", 16'(exec_valid), 16'h0);
        rd(rg(1), d); chk("R6 idle", d, 16'h0);
        rd(rg(0), d); chk("R6 ptr kept", d, 16'd5);
        rd(rg(4), d); chk("R6 flag", d, 16'h1);
        wr(rg(4), 16'h0001);
        wr(rg(2), 16'hBEEF);
        rd(rg(4), d); chk("R6 idle abort no flag", d, 16'h0);
        rd(rg(1), d); chk("R6 idle abort stays idle", d, 16'h0);
    endtask

    task automatic t_exempt();
        logic [15:0] d, c0, c1; int n;
        wr(rg(0), 16'd5);
        wait_valid();
        rd(rg(1), d); chk("R8 stat busy", d, 16'h1);
        wr(rg(5), 16'h0000);
        rd(rg(3), d); chk("R8 extoff reads 0", d, 16'h0);
        wr(rg(6), 16'hFFFF);
        rd(rg(4), d); chk("R8 istat read", d, 16'h0);
        chk("R8 still offered", 16'(exec_valid), 16'h1);
        chk("R8 cmd held", exec_cmd, 16'h0A55);
        serve(20, n, c0, c1);
        chk("R8 completed", 16'(n), 16'd1);
        rd(rg(0), d); chk("R8 ran to halt", d, 16'd6);
        wr(rg(4), 16'h0001);
    endtask

    task automatic t_violation();
        logic [15:0] d;
        wr(ra(20), 16'h0ABC);
        wr(rg(0), 16'd5);
        wait_valid();
        wr(ra(20), 16'h1234);
        chk("R7 ram write ends", 16'(exec_valid), 16'h0);
        rd(rg(4), d); chk("R7 flag", d, 16'h1);
        rd(ra(20), d); chk("R7 write dropped", d, 16'h0ABC);
        wr(rg(4), 16'h0001);
        wr(rg(0), 16'd5);
        wait_valid();
        rd(rg(0), d); chk("R7 ptr read refused", d, 16'h0);
        chk("R7 read ends", 16'(exec_valid), 16'h0);
        wr(rg(4), 16'h0001);
        wr(rg(0), 16'd5);
        wait_valid();
        wr(rg(0), 16'd9);
        chk("R7 ptr write ends", 16'(exec_valid), 16'h0);
        repeat (4) @(negedge clk);
        rd(rg(1), d); chk("R7 no restart", d, 16'h0);
        rd(rg(0), d); chk("R7 ptr unchanged", d, 16'd5);
        wr(rg(4), 16'h0001);
        wr(rg(0), 16'd5);
        wait_valid();
        wr(rg(7), 16'h0000);
        chk("R7 spare ends", 16'(exec_valid), 16'h0);
        wr(rg(4), 16'h0001);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_brk_irq();
        t_reserved();
        t_wrap();
        t_abort();
        t_exempt();
        t_violation();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule